// File: doc/BRIEF.md
# Output Range Clamp and Depth Expander

This block sits in an output pixel path just ahead of the link encoder. Each pixel has three components. Each component arrives MSB-aligned in a 12-bit field. The block first widens each component from its source depth to a full 12 bits. It then optionally limits the result to the legal video code range of a selected output depth. The result leaves through a single register stage, so the output lags the input by one clock cycle.

Widening can run in two modes. When it is enabled, the bits that fall below the source depth are filled with copies of the component's top bits. When it is disabled, those bits are zeroed. Clamping uses a 3-bit format code. Each supported code has a lower and an upper limit, computed as the legal codes of that depth promoted to 12 bits in the same way as the widening. A colour-space input selects whether channels 1 and 2 carry chroma, which has a higher upper limit.

Top module: `pix_range_clamp`

## Requirements
- R1: While rst_ni is low, and after it is released until the first valid pixel, vld_o is 0 and pix_o is all zeros.
- R2: vld_o equals vld_i delayed by one cycle. pix_o changes only in the cycle after a cycle with vld_i high, and it holds its value otherwise.
- R3: With exp_mode_i = 1 (8-bit source in bits [11:4]) and exp_en_i = 1, the output component is {in[11:4], in[11:8]}.
- R4: With exp_mode_i = 0 (10-bit source in bits [11:2]) and exp_en_i = 1, the output component is {in[11:2], in[11:10]}. The same mode serves 12-bit sources, where bits [1:0] are also overwritten by in[11:10].
- R5: With exp_en_i = 0, the vacated low bits are zero: 4 bits in mode 1 and 2 bits in mode 0.
- R6: Format code 1 (8-bit depth) limits components to 257..3774. When chroma is selected, channels 1 and 2 have an upper limit of 3855.
- R7: Format code 2 (10-bit depth) limits components to 256..3763. The chroma upper limit is 3843.
- R8: Format code 3 (12-bit depth) limits components to 256..3760. The chroma upper limit is 3840.
- R9: Format codes 0, 4, 5, 6 and 7, or clamp_en_i = 0, pass the widened value through unchanged.
- R10: With ycc_i = 1, channel 0 (bits [11:0]) uses the luma limits and channels 1 and 2 use the chroma limits. With ycc_i = 0, all three channels use the luma limits.
- R11: Widening happens before clamping, so the limits are compared with the filled 12-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vld_i | input | 1 | Input pixel valid |
| pix_i | input | 36 | Three MSB-aligned 12-bit components, channel 0 in [11:0] |
| ycc_i | input | 1 | 1: channels 1 and 2 are chroma |
| clamp_en_i | input | 1 | Clamp enable |
| clamp_fmt_i | input | 3 | Clamp depth code (1: 8 bit, 2: 10 bit, 3: 12 bit, other codes: no clamp) |
| exp_en_i | input | 1 | Fill the vacated low bits by replication |
| exp_mode_i | input | 1 | 0: 10-bit source, 1: 8-bit source |
| vld_o | output | 1 | Output pixel valid |
| pix_o | output | 36 | Widened and clamped components |

## Verification
The assertions check several properties on every cycle. They check the one-cycle valid delay and that the output holds while no pixel arrives. They check that channel 0 stays inside the 8-bit and 12-bit luma limits whenever those formats are active. They also check the replicated or zeroed low bits in the unclamped cases. Only the bench scenarios can show the exact limit values chosen for chroma against luma, and that codes 0 and 4 to 7 really pass data unchanged. Ordering effects also need the bench, such as a full-scale 8-bit value widened to 0xFFF and then clamped to the upper limit.

// File: rtl/pix_range_pkg.sv
package pix_range_pkg;
  localparam int CW = 12;

  typedef enum logic {
    EXP_SRC10 = 1'b0,
    EXP_SRC8  = 1'b1
  } exp_mode_e;

  // Legal code at depth d, promoted to CW bits with MSB fill
  function automatic logic [CW-1:0] lim_promote(input int base, input int d);
    int v;
    v = base << (d - 8);
    return CW'((v << (CW - d)) | (v >> (2 * d - CW)));
  endfunction

  localparam logic [CW-1:0] LO_8   = lim_promote(16, 8);
  localparam logic [CW-1:0] HI_Y8  = lim_promote(235, 8);
  localparam logic [CW-1:0] HI_C8  = lim_promote(240, 8);
  localparam logic [CW-1:0] LO_10  = lim_promote(16, 10);
  localparam logic [CW-1:0] HI_Y10 = lim_promote(235, 10);
  localparam logic [CW-1:0] HI_C10 = lim_promote(240, 10);
  localparam logic [CW-1:0] LO_12  = lim_promote(16, 12);
  localparam logic [CW-1:0] HI_Y12 = lim_promote(235, 12);
  localparam logic [CW-1:0] HI_C12 = lim_promote(240, 12);
endpackage

// File: rtl/pix_depth_expand.sv
module pix_depth_expand
  import pix_range_pkg::*;
(
  input  logic [CW-1:0] din_i,
  input  logic          en_i,
  input  exp_mode_e     mode_i,
  output logic [CW-1:0] dout_o
);
  always_comb begin
    if (mode_i == EXP_SRC8)
      dout_o = {din_i[CW-1:4], en_i ? din_i[CW-1:CW-4] : 4'b0};
    else
      dout_o = {din_i[CW-1:2], en_i ? din_i[CW-1:CW-2] : 2'b0};
  end
endmodule

// File: rtl/pix_limit_clamp.sv
module pix_limit_clamp
  import pix_range_pkg::*;
(
  input  logic [CW-1:0] din_i,
  input  logic          en_i,
  input  logic [2:0]    fmt_i,
  input  logic          chroma_i,
  output logic [CW-1:0] dout_o
);
  logic          act;
  logic [CW-1:0] lo, hi;

  always_comb begin
    act = en_i;
    lo  = '0;
    hi  = '1;
    unique case (fmt_i)
      3'd1: begin lo = LO_8;  hi = chroma_i ? HI_C8  : HI_Y8;  end
      3'd2: begin lo = LO_10; hi = chroma_i ? HI_C10 : HI_Y10; end
      3'd3: begin lo = LO_12; hi = chroma_i ? HI_C12 : HI_Y12; end
      default: act = 1'b0;
    endcase
  end

  always_comb begin
    if (!act)           dout_o = din_i;
    else if (din_i < lo) dout_o = lo;
    else if (din_i > hi) dout_o = hi;
    else                 dout_o = din_i;
  end
endmodule

// File: rtl/pix_range_clamp.sv
module pix_range_clamp
  import pix_range_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [NCH*CW-1:0] pix_i,
  input  logic             ycc_i,
  input  logic             clamp_en_i,
  input  logic [2:0]       clamp_fmt_i,
  input  logic             exp_en_i,
  input  logic             exp_mode_i,
  output logic             vld_o,
  output logic [NCH*CW-1:0] pix_o
);
  localparam int PW = NCH * CW;

  logic [PW-1:0] wide, lim;
  exp_mode_e     mode;

  assign mode = exp_mode_e'(exp_mode_i);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pix_depth_expand u_exp (
      .din_i  (pix_i[c*CW +: CW]),
      .en_i   (exp_en_i),
      .mode_i (mode),
      .dout_o (wide[c*CW +: CW])
    );
    pix_limit_clamp u_clp (
      .din_i    (wide[c*CW +: CW]),
      .en_i     (clamp_en_i),
      .fmt_i    (clamp_fmt_i),
      .chroma_i (ycc_i && (c != 0)),
      .dout_o   (lim[c*CW +: CW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      pix_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) pix_o <= lim;
    end
  end

  // R2
  vld_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  // R2
  vld_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(pix_o));
  // R6
  lim8_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && clamp_en_i && clamp_fmt_i == 3'd1)
      |=> (pix_o[CW-1:0] >= 12'd257 && pix_o[CW-1:0] <= 12'd3774));
  // R8
  lim12_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && clamp_en_i && clamp_fmt_i == 3'd3)
      |=> (pix_o[CW-1:0] >= 12'd256 && pix_o[CW-1:0] <= 12'd3760));
  // R3
  fill8_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clamp_en_i && exp_en_i && exp_mode_i)
      |=> pix_o[3:0] == pix_o[CW-1:CW-4]);
  // R5
  zero10_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clamp_en_i && !exp_en_i && !exp_mode_i)
      |=> pix_o[1:0] == 2'b00);
endmodule

// File: tb/sim_pix_range_clamp.sv
`timescale 1ns/1ps
module sim_pix_range_clamp;
  localparam int NV = 15;
  // {clamp_en, fmt, exp_en, mode, ycc, pix_in{c2,c1,c0}, expected{c2,c1,c0}}
  localparam logic [78:0] TBL [NV] = '{
    {1'b0,3'd0,1'b1,1'b1,1'b0,36'hFF0_120_AB0,36'hFFF_121_ABA}, // R3
    {1'b0,3'd0,1'b1,1'b0,1'b0,36'hFFD_123_ABC,36'hFFF_120_ABE}, // R4
    {1'b0,3'd0,1'b0,1'b1,1'b0,36'hFFF_12F_ABC,36'hFF0_120_AB0}, // R5
    {1'b0,3'd0,1'b0,1'b0,1'b0,36'hFFE_003_ABF,36'hFFC_000_ABC}, // R5
    {1'b1,3'd1,1'b1,1'b1,1'b0,36'h800_FF0_000,36'h808_EBE_101}, // R6 R11
    {1'b1,3'd1,1'b1,1'b1,1'b1,36'h050_FF0_FF0,36'h101_F0F_EBE}, // R6 R10
    {1'b1,3'd2,1'b1,1'b0,1'b0,36'h101_FFF_000,36'h100_EB3_100}, // R7
    {1'b1,3'd2,1'b1,1'b0,1'b1,36'h000_FFF_FFF,36'h100_F03_EB3}, // R7 R10
    {1'b1,3'd3,1'b0,1'b0,1'b1,36'h0FF_FFF_FFF,36'h100_F00_EB0}, // R8
    {1'b1,3'd0,1'b1,1'b1,1'b0,36'h050_FF0_000,36'h050_FFF_000}, // R9
    {1'b1,3'd7,1'b1,1'b1,1'b0,36'h050_FF0_000,36'h050_FFF_000}, // R9
    {1'b1,3'd5,1'b1,1'b1,1'b0,36'h050_FF0_000,36'h050_FFF_000}, // R9
    {1'b0,3'd1,1'b1,1'b1,1'b0,36'h800_FF0_000,36'h808_FFF_000}, // R9
    {1'b1,3'd3,1'b1,1'b0,1'b0,36'h555_0FF_EB1,36'h555_100_EB0}, // R8 R4
    {1'b1,3'd4,1'b1,1'b1,1'b1,36'h050_FF0_FF0,36'h050_FFF_FFF}  // R9 R10
  };
  localparam int REQ [NV] = '{3,4,5,5,6,6,7,7,8,9,9,9,9,8,9};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vld_i = 1'b0;
  logic [35:0] pix_i = '0;
  logic        ycc_i = 1'b0, clamp_en_i = 1'b0, exp_en_i = 1'b0, exp_mode_i = 1'b0;
  logic [2:0]  clamp_fmt_i = '0;
  logic        vld_o;
  logic [35:0] pix_o;
  int total = 0, bad = 0;

  always #10 clk_i = ~clk_i;

  pix_range_clamp u0 (.*);

  task automatic check(input int req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [35:0] last;
    repeat (3) @(negedge clk_i);
    check(1, {35'b0, vld_o}, 36'h0);  // R1 in reset
    check(1, pix_o, 36'h0);           // R1
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, pix_o, 36'h0);           // R1 after release

    for (int i = 0; i < NV; i++) begin
      {clamp_en_i, clamp_fmt_i, exp_en_i, exp_mode_i, ycc_i, pix_i} = TBL[i][78:36];
      vld_i = 1'b1;
      @(negedge clk_i);
      check(REQ[i], pix_o, TBL[i][35:0]);
    end

    // R2: idle cycle holds output and drops valid
    last = pix_o;
    vld_i = 1'b0;
    pix_i = 36'h123_456_789;
    clamp_en_i = 1'b0;
    @(negedge clk_i);
    check(2, {35'b0, vld_o}, 36'h0);
    check(2, pix_o, last);

    // R2: one-cycle latency
    vld_i = 1'b1;
    exp_en_i = 1'b1; exp_mode_i = 1'b1;
    pix_i = 36'h100_200_300;
    #1;
    check(2, pix_o, last);
    @(negedge clk_i);
    check(2, {35'b0, vld_o}, 36'h1);
    check(3, pix_o, 36'h101_202_303);  // R3
    vld_i = 1'b0;
    @(negedge clk_i);

    // R1: reset again clears outputs
    rst_ni = 1'b0;
    #1;
    check(1, pix_o, 36'h0);
    finish_run();
  end
endmodule